// File: doc/BRIEF.md
# Power-down mode sequencer

This block tracks which operating or low-power mode a small microcontroller core is in. Software sets a handful of configuration bits and then runs a sleep instruction. The decoder raises a one-cycle strobe for that instruction. The sequencer uses the strobe and the configuration bits to choose one of three low-power modes: sleep, standby or watch. It stays in that mode until a qualifying interrupt request wakes it. A wake goes to active medium-speed mode or to active high-speed mode.

Which requests can wake the block depends on the mode. In sleep mode any enabled request is enough. In standby and watch modes only the external-interrupt pins and the wakeup pins count. The global interrupt mask blocks every wake. A clear per-source enable bit blocks that source.

The mode code and the clock-divider select are both registered, so they change one clock after the event that causes the change. The clock generator downstream reads the divider select. The reset pin is active low and is sampled on the clock edge.

Top module: `pms_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mode` becomes 0 (reset) and `div_sel` becomes 0 one clock later. The first edge with `rst_n` high after that moves `mode` to 1 (high-speed), never to 2.
- R2: A `sleep_req` strobe in mode 1 or 2 with `cfg_standby`=0 and `cfg_lowspd`=0 moves `mode` to 3 (sleep) one clock later.
- R3: A `sleep_req` strobe in mode 1 or 2 with `cfg_standby`=1, `cfg_lowspd`=0 and `cfg_tmr_src`=0 moves `mode` to 4 (standby). A strobe with `cfg_standby`=1 and `cfg_tmr_src`=1 moves `mode` to 5 (watch), whatever `cfg_lowspd` is.
- R4: A `sleep_req` strobe in mode 1 or 2 with `cfg_lowspd`=1 that is not a watch case leaves `mode` unchanged.
- R5: In mode 3, any enabled request wakes the block one clock later. Enabled requests are `ext_irq`&`ext_en`, `wkp_irq`&`wkp_en` and `per_irq`&`per_en`.
- R6: In modes 4 and 5, only enabled `ext_irq` or `wkp_irq` requests wake the block. An enabled `per_irq` request leaves the mode unchanged.
- R7: No wake occurs while `gmask`=1, or when the requesting source's enable bit is 0.
- R8: A wake goes to mode 2 (medium-speed) when `cfg_medspd`=1 and `cfg_lowspd`=0, and to mode 1 (high-speed) otherwise.
- R9: A `sleep_req` strobe in mode 2 follows the same entry rules as in mode 1. A strobe in modes 3 to 5 is ignored. Wake requests in modes 1 and 2 are ignored.
- R10: `div_sel` holds log2 of the clock division ratio. In mode 2 it is 4 + `cfg_div`, so 00, 01, 10 and 11 give 4, 5, 6 and 7 (divide by 16, 32, 64, 128). In every other mode it is 0 (divide by 1). It is registered, so a change of `cfg_div` in mode 2 shows one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin, active low, sampled on the clock edge |
| sleep_req | input | 1 | One-cycle strobe marking a sleep instruction |
| cfg_standby | input | 1 | Standby select |
| cfg_lowspd | input | 1 | Low-speed select |
| cfg_medspd | input | 1 | Medium-speed select for wake target |
| cfg_tmr_src | input | 1 | Timer clock-source bit (selects watch) |
| cfg_div | input | 2 | Medium-speed divider field |
| gmask | input | 1 | Global interrupt mask |
| ext_irq | input | NX | External-interrupt pin requests |
| ext_en | input | NX | External-interrupt enables |
| wkp_irq | input | NW | Wakeup-pin requests |
| wkp_en | input | NW | Wakeup-pin enables |
| per_irq | input | NP | Other peripheral interrupt requests |
| per_en | input | NP | Peripheral interrupt enables |
| mode | output | 3 | Current mode: 0 reset, 1 high, 2 medium, 3 sleep, 4 standby, 5 watch |
| div_sel | output | 3 | log2 of clock division ratio |

## Verification
A wrong state register shows up on `mode` one clock after the strobe or request that should have moved it. The most likely fault is a wake source qualified against the wrong mode, and it shows up only when a peripheral request arrives in standby or watch mode. Each such stimulus is followed by a port check on the next cycle. A divider code that lags or leads the mode shows up on `div_sel` at the same edge as the mode change. The bench also changes the divider field while the block stays in medium-speed mode, to catch a code that does not follow the field.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;
  typedef enum logic [2:0] {
    M_RST   = 3'd0,
    M_HIGH  = 3'd1,
    M_MED   = 3'd2,
    M_SLEEP = 3'd3,
    M_STBY  = 3'd4,
    M_WATCH = 3'd5
  } pmode_t;

  localparam int DIV_FW = 2;             // divider field width
  localparam int DIV_OW = DIV_FW + 1;    // divider code width
  localparam logic [DIV_OW-1:0] DIV_BASE = DIV_OW'(4); // log2(16)
  localparam logic [DIV_OW-1:0] DIV_NONE = '0;
endpackage

// File: rtl/pms_wake_detect.sv
`timescale 1ns/1ps
module pms_wake_detect #(
  parameter int NX = 2,
  parameter int NW = 8,
  parameter int NP = 4
) (
  input  logic          gmask,
  input  logic [NX-1:0] ext_irq,
  input  logic [NX-1:0] ext_en,
  input  logic [NW-1:0] wkp_irq,
  input  logic [NW-1:0] wkp_en,
  input  logic [NP-1:0] per_irq,
  input  logic [NP-1:0] per_en,
  output logic          wake_pin,
  output logic          wake_any
);
  logic pin_hit, per_hit;

  assign pin_hit  = (|(ext_irq & ext_en)) | (|(wkp_irq & wkp_en));
  assign per_hit  = |(per_irq & per_en);
  assign wake_pin = !gmask & pin_hit;
  assign wake_any = !gmask & (pin_hit | per_hit);
endmodule

// File: rtl/pms_entry_decode.sv
`timescale 1ns/1ps
module pms_entry_decode
  import pms_pkg::*;
(
  input  logic   sleep_req,
  input  logic   cfg_standby,
  input  logic   cfg_lowspd,
  input  logic   cfg_medspd,
  input  logic   cfg_tmr_src,
  output logic   entry_ok,
  output pmode_t entry_mode,
  output pmode_t wake_mode
);
  logic to_watch, to_stby, to_sleep;

  assign to_watch = cfg_standby & cfg_tmr_src;
  assign to_stby  = cfg_standby & !cfg_lowspd & !cfg_tmr_src;
  assign to_sleep = !cfg_standby & !cfg_lowspd;
  assign entry_ok = sleep_req & (to_watch | to_stby | to_sleep);

  always_comb begin
    if (to_watch)     entry_mode = M_WATCH;
    else if (to_stby) entry_mode = M_STBY;
    else              entry_mode = M_SLEEP;
  end

  assign wake_mode = (cfg_medspd & !cfg_lowspd) ? M_MED : M_HIGH;
endmodule

// File: rtl/pms_div_sel.sv
`timescale 1ns/1ps
module pms_div_sel
  import pms_pkg::*;
(
  input  pmode_t            nxt_mode,
  input  logic [DIV_FW-1:0] cfg_div,
  output logic [DIV_OW-1:0] div_nxt
);
  assign div_nxt = (nxt_mode == M_MED) ? (DIV_BASE + DIV_OW'(cfg_div)) : DIV_NONE;
endmodule

// File: rtl/pms_top.sv
`timescale 1ns/1ps
module pms_top
  import pms_pkg::*;
#(
  parameter int NX = 2,
  parameter int NW = 8,
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          cfg_standby,
  input  logic          cfg_lowspd,
  input  logic          cfg_medspd,
  input  logic          cfg_tmr_src,
  input  logic [1:0]    cfg_div,
  input  logic          gmask,
  input  logic [NX-1:0] ext_irq,
  input  logic [NX-1:0] ext_en,
  input  logic [NW-1:0] wkp_irq,
  input  logic [NW-1:0] wkp_en,
  input  logic [NP-1:0] per_irq,
  input  logic [NP-1:0] per_en,
  output logic [2:0]    mode,
  output logic [2:0]    div_sel
);
  pmode_t            mode_q, mode_d;
  logic [DIV_OW-1:0] div_q, div_d;
  logic              wake_pin, wake_any, entry_ok;
  pmode_t            entry_mode, wake_mode;

  pms_wake_detect #(.NX(NX), .NW(NW), .NP(NP)) u_wake (
    .gmask(gmask), .ext_irq(ext_irq), .ext_en(ext_en),
    .wkp_irq(wkp_irq), .wkp_en(wkp_en),
    .per_irq(per_irq), .per_en(per_en),
    .wake_pin(wake_pin), .wake_any(wake_any)
  );

  pms_entry_decode u_entry (
    .sleep_req(sleep_req), .cfg_standby(cfg_standby),
    .cfg_lowspd(cfg_lowspd), .cfg_medspd(cfg_medspd),
    .cfg_tmr_src(cfg_tmr_src), .entry_ok(entry_ok),
    .entry_mode(entry_mode), .wake_mode(wake_mode)
  );

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_RST:           mode_d = M_HIGH;
      M_HIGH, M_MED:   if (entry_ok) mode_d = entry_mode;
      M_SLEEP:         if (wake_any) mode_d = wake_mode;
      M_STBY, M_WATCH: if (wake_pin) mode_d = wake_mode;
      default:         mode_d = M_RST;
    endcase
  end

  pms_div_sel u_div (.nxt_mode(mode_d), .cfg_div(cfg_div), .div_nxt(div_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_RST;
      div_q  <= DIV_NONE;
    end else begin
      mode_q <= mode_d;
      div_q  <= div_d;
    end
  end

  assign mode    = mode_q;
  assign div_sel = div_q;
endmodule

// File: rtl/pms_checker.sv
`timescale 1ns/1ps
module pms_checker #(
  parameter int NX = 2,
  parameter int NW = 8,
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_req,
  input logic          cfg_standby,
  input logic          cfg_lowspd,
  input logic          cfg_medspd,
  input logic          cfg_tmr_src,
  input logic [1:0]    cfg_div,
  input logic          gmask,
  input logic [NX-1:0] ext_irq,
  input logic [NX-1:0] ext_en,
  input logic [NW-1:0] wkp_irq,
  input logic [NW-1:0] wkp_en,
  input logic [NP-1:0] per_irq,
  input logic [NP-1:0] per_en,
  input logic [2:0]    mode,
  input logic [2:0]    div_sel
);
  logic active, deep, pins;
  assign active = (mode == 3'd1) || (mode == 3'd2);
  assign deep   = (mode == 3'd4) || (mode == 3'd5);
  assign pins   = (|(ext_irq & ext_en)) || (|(wkp_irq & wkp_en));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (mode == 3'd0 && div_sel == 3'd0));

  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> (mode == 3'd1));

  assert_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sleep_req && !cfg_standby && !cfg_lowspd) |=> (mode == 3'd3));

  assert_watch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sleep_req && cfg_standby && cfg_tmr_src) |=> (mode == 3'd5));

  assert_per_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (deep && !pins) |=> $stable(mode));

  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd3 || deep) && gmask) |=> $stable(mode));

  assert_div_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd2) |-> (div_sel == 3'd0));

  assert_div_med_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> div_sel[2]);

  assert_range: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd5);
endmodule

bind pms_top pms_checker #(.NX(NX), .NW(NW), .NP(NP)) u_chk (.*);

// File: tb/sim_pms_top.sv
`timescale 1ns/1ps
module sim_pms_top;
  localparam int NX = 2, NW = 8, NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic cfg_standby = 1'b0, cfg_lowspd = 1'b0, cfg_medspd = 1'b0, cfg_tmr_src = 1'b0;
  logic [1:0] cfg_div = 2'd0;
  logic gmask = 1'b0;
  logic [NX-1:0] ext_irq = '0, ext_en = '0;
  logic [NW-1:0] wkp_irq = '0, wkp_en = '0;
  logic [NP-1:0] per_irq = '0, per_en = '0;
  logic [2:0] mode, div_sel;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pms_top #(.NX(NX), .NW(NW), .NP(NP)) u0 (.*);

  typedef struct packed {
    logic sb, ls, ms, tm;
    logic [1:0] dv;
    logic x, w, p, gm, en;
    logic [2:0] es, ew, ed;
  } vec_t;

  // sb ls ms tm dv | x w p gm en | sleep-mode wake-mode div
  localparam vec_t TBL [13] = '{
    '{0,0,1,0,2'd0, 1,0,0,0,1, 3'd3,3'd2,3'd4}, // R2 R5 R8 R10
    '{0,0,1,0,2'd3, 0,0,1,0,1, 3'd3,3'd2,3'd7}, // R5 peripheral wakes sleep
    '{0,0,0,0,2'd1, 0,0,1,0,1, 3'd3,3'd1,3'd0}, // R8 to high-speed
    '{1,0,1,0,2'd1, 1,0,0,0,1, 3'd4,3'd2,3'd5}, // R3 standby
    '{1,0,1,0,2'd0, 0,0,1,0,1, 3'd4,3'd4,3'd0}, // R6 peripheral ignored
    '{1,0,1,1,2'd2, 0,1,0,0,1, 3'd5,3'd2,3'd6}, // R3 watch
    '{1,0,1,1,2'd0, 0,0,1,0,1, 3'd5,3'd5,3'd0}, // R6 watch
    '{1,1,1,1,2'd0, 0,1,0,0,1, 3'd5,3'd1,3'd0}, // R3 R8 watch with lowspd
    '{0,0,1,0,2'd0, 1,0,0,1,1, 3'd3,3'd3,3'd0}, // R7 mask
    '{1,0,1,0,2'd0, 0,1,0,0,0, 3'd4,3'd4,3'd0}, // R7 enable off
    '{0,1,1,0,2'd0, 1,0,0,0,1, 3'd1,3'd1,3'd0}, // R4 no entry
    '{1,1,1,0,2'd0, 1,0,0,0,1, 3'd1,3'd1,3'd0}, // R4 no entry
    '{1,0,0,0,2'd0, 0,1,0,0,1, 3'd4,3'd1,3'd0}  // R8 standby to high
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_irq();
    ext_irq = '0; wkp_irq = '0; per_irq = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe();
    sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_irq[0] = 1'b1;
    @(negedge clk); clear_irq();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk); @(negedge clk);
    chk("R1 mode in reset", mode, 3'd0);
    chk("R1 div in reset", div_sel, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 release to high", mode, 3'd1);

    foreach (TBL[i]) begin
      do_reset();
      cfg_standby = TBL[i].sb; cfg_lowspd = TBL[i].ls;
      cfg_medspd = TBL[i].ms; cfg_tmr_src = TBL[i].tm; cfg_div = TBL[i].dv;
      ext_en = TBL[i].en ? '1 : '0;
      wkp_en = TBL[i].en ? '1 : '0;
      per_en = TBL[i].en ? '1 : '0;
      gmask = 1'b0;
      strobe();
      chk($sformatf("R2/R3/R4 entry vec %0d", i), mode, TBL[i].es);
      gmask = TBL[i].gm;
      ext_irq[0] = TBL[i].x; wkp_irq[3] = TBL[i].w; per_irq[1] = TBL[i].p;
      @(negedge clk); clear_irq(); gmask = 1'b0;
      chk($sformatf("R5/R6/R7/R8 wake vec %0d", i), mode, TBL[i].ew);
      chk($sformatf("R10 div vec %0d", i), div_sel, TBL[i].ed);
    end

    // Medium-speed path, R9 and R10 corners
    do_reset();
    ext_en = '1; wkp_en = '1; per_en = '1;
    cfg_standby = 0; cfg_lowspd = 0; cfg_medspd = 1; cfg_tmr_src = 0; cfg_div = 2'd0;
    strobe();
    chk("R2 sleep", mode, 3'd3);
    pulse_ext();
    chk("R8 wake medium", mode, 3'd2);
    chk("R10 div 16", div_sel, 3'd4);
    cfg_div = 2'd2;
    @(negedge clk);
    chk("R10 live div 64", div_sel, 3'd6);
    pulse_ext();
    chk("R9 wake ignored in medium", mode, 3'd2);
    cfg_standby = 1;
    strobe();
    chk("R9 medium to standby", mode, 3'd4);
    chk("R10 div idle in standby", div_sel, 3'd0);
    cfg_standby = 0;
    strobe();
    chk("R9 strobe ignored in standby", mode, 3'd4);
    pulse_ext();
    chk("R9 back to medium", mode, 3'd2);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset from medium", mode, 3'd0);
    chk("R1 div cleared", div_sel, 3'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 release not medium", mode, 3'd1);
    pulse_ext();
    chk("R9 wake ignored in high", mode, 3'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule